// File: doc/BRIEF.md
# Servo Pulse Level Qualifier

This block finds pulses in a stream of signed digitized read samples. It compares each sample with a threshold magnitude that applies to both polarities. A sample counts as a pulse when it lies strictly above the positive limit or strictly below the negative one. Only the first sample of each excursion outside the window counts. The block then reports a one-cycle qualified strobe and a polarity flag.

Two gates select how the block works:
- While the servo gate is high, the block uses the servo threshold register and drives its outputs.
- While only the read gate is high, it switches to the data threshold register and keeps tracking excursions, but its outputs stay inactive.
- With both gates low, it does nothing.

A mode bit selects plain window qualification or hysteresis qualification. Hysteresis qualification passes only pulses whose polarity alternates. A second bit sets whether the strobe is active-high or active-low.

Top module: `servo_pulse_qualifier`

## Requirements
- R1: During and right after reset, the strobe sits at its inactive level and `pulse_neg_o` is 0. The inactive level is low when `strobe_hi_i`=1 and high when `strobe_hi_i`=0.
- R2: Take a gated sample whose value is strictly greater than the selected threshold (threshold T, 0..63). The strobe is active for exactly one cycle, one clock after that sample, with `pulse_neg_o`=0. A sample equal to +T is not a pulse.
- R3: A gated sample strictly below -T is a negative pulse. Its strobe comes with `pulse_neg_o`=1. A sample equal to -T is not a pulse. `pulse_neg_o` is 1 only in a strobe cycle.
- R4: Only the first sample of a contiguous excursion beyond a threshold is a pulse. Another pulse needs at least one sample inside the window (|s| <= T) first. A direct jump from above +T to below -T gives no pulse.
- R5: While the servo gate is high, `servo_thr_i` sets T, even if the read gate is also high. While only the read gate is high, `data_thr_i` sets T.
- R6: With only the read gate high, the strobe and `pulse_neg_o` stay inactive, but excursion tracking still runs. Example: an excursion that starts under the read gate and continues when the servo gate takes over gives no strobe.
- R7: With `hyst_mode_i`=0 (window mode), consecutive pulses of the same polarity each give a strobe.
- R8: With `hyst_mode_i`=1 (hysteresis mode), a pulse whose polarity equals that of the last accepted pulse is rejected. A pulse of the opposite polarity is accepted. A rejected pulse still ends the excursion.
- R9: The memory of the last accepted polarity clears on every cycle with the servo gate low. So the first pulse after the servo gate rises is always accepted.
- R10: With `strobe_hi_i`=1 the strobe is active-high. With `strobe_hi_i`=0 it is active-low. The bit acts on the output level directly.
- R11: With both gates low, no pulse is detected and the excursion tracker re-arms. A sample already outside the window when the servo gate rises is therefore a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | SAMPLE_W | Signed read sample, one per clock |
| servo_gate_i | input | 1 | Servo read window; enables the outputs |
| read_gate_i | input | 1 | Data read window |
| servo_thr_i | input | THR_W | Threshold magnitude for servo reads |
| data_thr_i | input | THR_W | Threshold magnitude for data reads |
| hyst_mode_i | input | 1 | 0 = window mode, 1 = hysteresis mode |
| strobe_hi_i | input | 1 | 1 = strobe active-high, 0 = active-low |
| qual_strobe_o | output | 1 | Qualified-pulse strobe |
| pulse_neg_o | output | 1 | 1 when the strobed pulse is negative |

## Verification
The hardest situation to reach from the ports is an excursion that crosses a change of gate. In that case the outcome depends on tracking state built up while the outputs were silent. The stimulus reaches it in two ways:
- It raises the read gate with a sample above the data threshold, then hands over to the servo gate in the very next cycle while holding the sample outside. No strobe should appear.
- It drops both gates with the sample still outside, then raises the servo gate. A strobe should appear.

A similar case is the hysteresis memory, which is only visible through what the next pulse does. A burst of positive pulses is followed by a short servo-gate low, and the bench checks that the next positive pulse is accepted. A long random stretch, with gates, thresholds and modes changing, is compared cycle by cycle against a behavioural model.

// File: rtl/spq_pkg.sv
// Package: shared types and helpers for the servo pulse level qualifier.
// Assumes samples are two's complement and thresholds are unsigned magnitudes.
package spq_pkg;

    // Position of one sample relative to the symmetric threshold window.
    typedef enum logic [1:0] {
        LVL_INSIDE = 2'b00,
        LVL_ABOVE  = 2'b01,
        LVL_BELOW  = 2'b10
    } level_e;

endpackage

// File: rtl/spq_thr_select.sv
// Module: spq_thr_select
// Picks the active threshold magnitude from the gate states. The servo gate
// has priority over the read gate. The module also reports whether any gate
// is open and widens the magnitude to the signed compare width.
// Assumes EXT_W > THR_W so the widened value is always non-negative.
module spq_thr_select #(
    parameter int THR_W = 6,
    parameter int EXT_W = 9
) (
    input  logic             servo_gate_i,
    input  logic             read_gate_i,
    input  logic [THR_W-1:0] servo_thr_i,
    input  logic [THR_W-1:0] data_thr_i,
    output logic             gate_open_o,
    output logic [EXT_W-1:0] pos_lim_o,
    output logic [EXT_W-1:0] neg_lim_o
);

    localparam int PAD_W = EXT_W - THR_W;

    logic [THR_W-1:0] thr_mag;

    // Threshold source: servo register first, data register otherwise.
    always_comb begin
        if (servo_gate_i) begin
            thr_mag = servo_thr_i;
        end else if (read_gate_i) begin
            thr_mag = data_thr_i;
        end else begin
            thr_mag = '0;
        end
    end

    // Symmetric limits in the signed compare domain.
    always_comb begin
        pos_lim_o   = {{PAD_W{1'b0}}, thr_mag};
        neg_lim_o   = '0 - pos_lim_o;
        gate_open_o = servo_gate_i | read_gate_i;
    end

endmodule

// File: rtl/spq_pulse_detect.sv
// Module: spq_pulse_detect
// Classifies each sample against the window and flags the first sample of
// every excursion beyond either limit. The tracker re-arms only after a
// sample inside the window, or whenever no gate is open.
// Assumes the limits are already in the EXT_W signed domain.
module spq_pulse_detect
    import spq_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int EXT_W    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                gate_open_i,
    input  logic [EXT_W-1:0]    pos_lim_i,
    input  logic [EXT_W-1:0]    neg_lim_i,
    output logic                hit_o,
    output logic                hit_neg_o
);

    localparam int SGN_PAD = EXT_W - SAMPLE_W;

    logic signed [EXT_W-1:0] s_ext;
    level_e                  level;
    logic                    armed_q;

    // Sign-extend the sample and place it relative to the window.
    always_comb begin
        s_ext = $signed({{SGN_PAD{sample_i[SAMPLE_W-1]}}, sample_i});
        if (s_ext > $signed(pos_lim_i)) begin
            level = LVL_ABOVE;
        end else if (s_ext < $signed(neg_lim_i)) begin
            level = LVL_BELOW;
        end else begin
            level = LVL_INSIDE;
        end
    end

    // Pulse event: armed tracker meets a sample outside the window.
    always_comb begin
        hit_o     = gate_open_i && armed_q && (level != LVL_INSIDE);
        hit_neg_o = (level == LVL_BELOW);
    end

    // Excursion tracker: disarm outside the window, re-arm inside or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (!gate_open_i) begin
            armed_q <= 1'b1;
        end else begin
            armed_q <= (level == LVL_INSIDE);
        end
    end

endmodule

// File: rtl/spq_hyst_filter.sv
// Module: spq_hyst_filter
// Accepts or rejects detected pulses. In hysteresis mode a pulse with the
// same polarity as the last accepted one is dropped. The polarity memory is
// updated in both modes and clears on any cycle with the servo gate low.
// Assumes hit_i is already gated by an open read or servo window.
module spq_hyst_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic hit_neg_i,
    input  logic hyst_mode_i,
    input  logic servo_gate_i,
    output logic accept_o
);

    logic mem_valid_q;
    logic mem_neg_q;
    logic repeat_pol;

    // Rejection test against the remembered polarity.
    always_comb begin
        repeat_pol = mem_valid_q && (mem_neg_q == hit_neg_i);
        accept_o   = hit_i && !(hyst_mode_i && repeat_pol);
    end

    // Polarity memory: cleared outside servo reads, loaded on each acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid_q <= 1'b0;
            mem_neg_q   <= 1'b0;
        end else if (!servo_gate_i) begin
            mem_valid_q <= 1'b0;
            mem_neg_q   <= 1'b0;
        end else if (accept_o) begin
            mem_valid_q <= 1'b1;
            mem_neg_q   <= hit_neg_i;
        end
    end

endmodule

// File: rtl/servo_pulse_qualifier.sv
// Module: servo_pulse_qualifier (top)
// Level qualifier for servo reads. It selects the threshold, detects
// excursions, applies optional polarity hysteresis and registers a one-cycle
// strobe plus polarity. The outputs only fire for samples taken with the
// servo gate high. The strobe level follows strobe_hi_i.
// Assumes SAMPLE_W > THR_W.
module servo_pulse_qualifier #(
    parameter int SAMPLE_W = 8,
    parameter int THR_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                servo_gate_i,
    input  logic                read_gate_i,
    input  logic [THR_W-1:0]    servo_thr_i,
    input  logic [THR_W-1:0]    data_thr_i,
    input  logic                hyst_mode_i,
    input  logic                strobe_hi_i,
    output logic                qual_strobe_o,
    output logic                pulse_neg_o
);

    localparam int EXT_W = SAMPLE_W + 1;

    logic             gate_open;
    logic [EXT_W-1:0] pos_lim;
    logic [EXT_W-1:0] neg_lim;
    logic             hit;
    logic             hit_neg;
    logic             accept;
    logic             strobe_q;
    logic             neg_q;

    spq_thr_select #(.THR_W(THR_W), .EXT_W(EXT_W)) u_thr (
        .servo_gate_i (servo_gate_i),
        .read_gate_i  (read_gate_i),
        .servo_thr_i  (servo_thr_i),
        .data_thr_i   (data_thr_i),
        .gate_open_o  (gate_open),
        .pos_lim_o    (pos_lim),
        .neg_lim_o    (neg_lim)
    );

    spq_pulse_detect #(.SAMPLE_W(SAMPLE_W), .EXT_W(EXT_W)) u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (sample_i),
        .gate_open_i (gate_open),
        .pos_lim_i   (pos_lim),
        .neg_lim_i   (neg_lim),
        .hit_o       (hit),
        .hit_neg_o   (hit_neg)
    );

    spq_hyst_filter u_hyst (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_i        (hit),
        .hit_neg_i    (hit_neg),
        .hyst_mode_i  (hyst_mode_i),
        .servo_gate_i (servo_gate_i),
        .accept_o     (accept)
    );

    // Output register: strobe and polarity only for servo-gated acceptances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            neg_q    <= 1'b0;
        end else begin
            strobe_q <= accept && servo_gate_i;
            neg_q    <= accept && servo_gate_i && hit_neg;
        end
    end

    // Output drive: strobe level set live by the polarity bit.
    always_comb begin
        qual_strobe_o = strobe_hi_i ? strobe_q : ~strobe_q;
        pulse_neg_o   = neg_q;
    end

endmodule

// File: rtl/spq_checker.sv
// Module: spq_checker
// Port-level properties of the qualifier, bound into the top module.
// It keeps its own record of the last strobed polarity for the hysteresis
// check.
module spq_checker #(
    parameter int SAMPLE_W = 8,
    parameter int THR_W    = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SAMPLE_W-1:0] sample_i,
    input logic                servo_gate_i,
    input logic [THR_W-1:0]    servo_thr_i,
    input logic                hyst_mode_i,
    input logic                strobe_hi_i,
    input logic                qual_strobe_o,
    input logic                pulse_neg_o
);

    localparam int EXT_W = SAMPLE_W + 1;

    logic                    act;
    logic signed [EXT_W-1:0] s_w;
    logic signed [EXT_W-1:0] t_w;
    logic                    seen_q;
    logic                    last_neg_q;

    // Observed strobe activity and widened operands for the limit checks.
    always_comb begin
        act = (qual_strobe_o == strobe_hi_i);
        s_w = $signed({sample_i[SAMPLE_W-1], sample_i});
        t_w = $signed({{(EXT_W-THR_W){1'b0}}, servo_thr_i});
    end

    // Shadow record of the last strobed polarity within a servo burst.
    always_ff @(posedge clk) begin
        if (!rst_n || !servo_gate_i) begin
            seen_q     <= 1'b0;
            last_neg_q <= 1'b0;
        end else if (act) begin
            seen_q     <= 1'b1;
            last_neg_q <= pulse_neg_o;
        end
    end

    AST_SINGLE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> !act); // R4
    AST_STROBE_NEEDS_SERVO: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> $past(servo_gate_i)); // R6
    AST_NEG_FLAG_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_neg_o |-> act); // R3
    AST_POS_ABOVE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !pulse_neg_o) |-> ($past(s_w) > $past(t_w))); // R2
    AST_NEG_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_neg_o |-> ($past(s_w) < -$past(t_w))); // R3
    AST_HYST_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(hyst_mode_i) && seen_q) |-> (pulse_neg_o != last_neg_q)); // R8

endmodule

bind servo_pulse_qualifier spq_checker #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_i      (sample_i),
    .servo_gate_i  (servo_gate_i),
    .servo_thr_i   (servo_thr_i),
    .hyst_mode_i   (hyst_mode_i),
    .strobe_hi_i   (strobe_hi_i),
    .qual_strobe_o (qual_strobe_o),
    .pulse_neg_o   (pulse_neg_o)
);

// File: tb/sim_servo_pulse_qualifier.sv
// Bench: behavioural reference model compared on every clock, plus
// directed expectations for each requirement.
module sim_servo_pulse_qualifier;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sample = '0;
    logic       sg = 1'b0, rg = 1'b0, hyst = 1'b0, hi = 1'b1;
    logic [5:0] sthr = 6'd20, dthr = 6'd40;
    logic       q_strobe, q_neg;

    int n_vec = 0;
    int n_bad = 0;

    // reference model state
    int m_armed = 1, m_hv = 0, m_hl = 0, e_act = 0, e_neg = 0;

    always #10 clk = ~clk;

    servo_pulse_qualifier u0 (
        .clk(clk), .rst_n(rst_n), .sample_i(sample),
        .servo_gate_i(sg), .read_gate_i(rg),
        .servo_thr_i(sthr), .data_thr_i(dthr),
        .hyst_mode_i(hyst), .strobe_hi_i(hi),
        .qual_strobe_o(q_strobe), .pulse_neg_o(q_neg)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive, advance model at the edge, compare away from the edge.
    task automatic step(input int s, input string tag);
        int thr, sv, outside, neg, hit, acc;
        sample = 8'(s);
        @(posedge clk);
        sv  = $signed(sample);
        thr = sg ? int'(sthr) : (rg ? int'(dthr) : 0);
        hit = 0; neg = 0;
        if (!sg && !rg) begin
            m_armed = 1;
        end else begin
            outside = (sv > thr) || (sv < -thr);
            neg     = (sv < -thr);
            hit     = m_armed && outside;
            m_armed = !outside;
        end
        acc   = hit && !(hyst && m_hv && (m_hl == neg));
        e_act = acc && sg;
        e_neg = e_act && neg;
        if (!sg) begin m_hv = 0; m_hl = 0; end
        else if (acc) begin m_hv = 1; m_hl = neg; end
        @(negedge clk);
        check((q_strobe == hi) == e_act, {tag, " strobe"}, int'(q_strobe == hi), e_act);
        check(q_neg == e_neg, {tag, " polarity"}, int'(q_neg), e_neg);
    endtask

    // Directed expectation on the result of the last stepped sample.
    task automatic want(input int act, input int neg, input string tag);
        check(int'(q_strobe == hi) == act, {tag, " directed strobe"}, int'(q_strobe == hi), act);
        check(int'(q_neg) == neg, {tag, " directed polarity"}, int'(q_neg), neg);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_vec++; n_bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset level for both strobe polarities
        sg = 1'b1; sample = 8'd100;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(q_strobe == 1'b0, "R1 idle high-active", int'(q_strobe), 0);
        check(q_neg == 1'b0, "R1 neg idle", int'(q_neg), 0);
        hi = 1'b0; #1;
        check(q_strobe == 1'b1, "R1 idle low-active", int'(q_strobe), 1);
        hi = 1'b1; sg = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R2: strict positive compare, single-cycle strobe
        sg = 1'b1; sthr = 6'd20;
        step(0, "R2");  want(0, 0, "R2");
        step(20, "R2"); want(0, 0, "R2 equal");
        step(0, "R2");
        step(21, "R2"); want(1, 0, "R2 above");
        step(25, "R2"); want(0, 0, "R2 one cycle");
        step(0, "R2");
        // R3: negative side
        step(-20, "R3"); want(0, 0, "R3 equal");
        step(0, "R3");
        step(-21, "R3"); want(1, 1, "R3 below");
        step(0, "R3");
        // R4: direct crossing without re-entry is not a pulse
        step(30, "R4");  want(1, 0, "R4 first");
        step(30, "R4");  want(0, 0, "R4 held");
        step(-30, "R4"); want(0, 0, "R4 cross");
        step(0, "R4");
        step(-30, "R4"); want(1, 1, "R4 rearmed");
        step(0, "R4");
        // R5: servo threshold wins with both gates open
        sthr = 6'd10; dthr = 6'd40; rg = 1'b1;
        step(11, "R5"); want(1, 0, "R5 servo priority");
        step(0, "R5");
        // R6: data read silent, tracking continues into servo gate
        sg = 1'b0;
        step(50, "R6");  want(0, 0, "R6 silent pos");
        step(0, "R6");
        step(-50, "R6"); want(0, 0, "R6 silent neg");
        step(0, "R6");
        step(50, "R6");
        sg = 1'b1; rg = 1'b0;
        step(50, "R6"); want(0, 0, "R6 carried excursion");
        step(0, "R6");
        step(50, "R6"); want(1, 0, "R6 fresh");
        step(0, "R6");
        // R7: window mode passes repeats
        step(30, "R7"); want(1, 0, "R7 first");
        step(0, "R7");
        step(30, "R7"); want(1, 0, "R7 repeat");
        step(0, "R7");
        // R8: hysteresis mode alternation
        hyst = 1'b1;
        step(30, "R8");  want(0, 0, "R8 repeat pos rejected");
        step(0, "R8");
        step(-30, "R8"); want(1, 1, "R8 alternate");
        step(0, "R8");
        step(-30, "R8"); want(0, 0, "R8 repeat neg rejected");
        step(0, "R8");
        step(30, "R8");  want(1, 0, "R8 alternate back");
        step(0, "R8");
        // R9: servo gate low clears the polarity memory
        sg = 1'b0;
        step(0, "R9");
        sg = 1'b1;
        step(30, "R9"); want(1, 0, "R9 first after burst");
        step(0, "R9");
        // R10: active-low strobe
        hi = 1'b0; hyst = 1'b0;
        step(0, "R10");  check(q_strobe == 1'b1, "R10 idle high", int'(q_strobe), 1);
        step(-30, "R10"); check(q_strobe == 1'b0, "R10 active low", int'(q_strobe), 0);
        step(0, "R10");
        hi = 1'b1;
        // R11: idle re-arms the tracker
        step(60, "R11");  want(1, 0, "R11 pulse");
        sg = 1'b0;
        step(60, "R11");  want(0, 0, "R11 no gate");
        sg = 1'b1;
        step(60, "R11");  want(1, 0, "R11 rearmed by idle");

        // mixed random stretch against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                sg = 1'($urandom_range(0, 2) != 0);
                rg = 1'($urandom_range(0, 1));
            end
            if ($urandom_range(0, 63) == 0) begin
                sthr = 6'($urandom_range(0, 63));
                dthr = 6'($urandom_range(0, 63));
                hyst = 1'($urandom_range(0, 1));
                hi   = 1'($urandom_range(0, 1));
            end
            step($urandom_range(0, 3) == 0 ? 0 : int'($urandom_range(0, 255)) - 128, "R2 R3 R4 R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule